// File: doc/BRIEF.md
# Cascaded Event Interrupt Aggregator

This block gathers hardware event pulses into three 32-bit pending words. Each event carries a 7-bit number. Three interrupt levels, called A, B and C, each have one mask word per pending word. A level's output is high while any pending bit under its mask is set. The block drives three level-sensitive interrupt lines toward a downstream interrupt controller.

A register port lets software read the pending words and clear them by writing ones. Software also reads and programs the nine mask words through this port. A second hardware port lets a source withdraw one pending event by number.

Events in the second and third words are also summarised into two reserved cascade bits at the top of the first word. A handler can therefore find every source by reading word 0 first. Software cannot clear the cascade bits. Each one follows its upper word and drops only when that word is empty.

Top module: `evt_cascade_agg`

## Requirements
- R1: An event pulse (`evt_valid` with `evt_id`) selects pending word `evt_id[6:5]` and bit `evt_id[4:0]`, and sets that bit on the next clock edge. The pending words read back at byte offsets 0x00, 0x04 and 0x08.
- R2: Event and clear numbers with word field 3 (96 to 127) have no effect. Numbers 30 and 31, which fall on the cascade bits of word 0, also have no effect.
- R3: An event in word 1 also sets bit 30 of word 0. An event in word 2 also sets bit 31 of word 0.
- R4: A bus write to word 0 clears each bit written as one, except bits 31 and 30, which the write leaves unchanged.
- R5: A bus write to word 1 changes nothing.
- R6: A bus write to word 2 clears each bit written as one. When word 2 becomes empty, bit 31 of word 0 drops in the same edge.
- R7: The clear port (`clr_valid` with `clr_id`) clears one pending bit, using the same number encoding as events. When that clear empties word 1, bit 30 of word 0 drops. When it empties word 2, bit 31 of word 0 drops.
- R8: `irq[0]`, `irq[1]` and `irq[2]` are high exactly when some pending bit ANDed with its mask is set for level A, B or C respectively. The mask words for word w sit at byte offset 0x0C+4w (A), 0x18+4w (B) and 0x24+4w (C), and they read back. An output follows a pending change or a mask write on the same edge that updates the register.
- R9: An event on a bit wins over a clear of that bit in the same cycle, whether the clear comes from the bus or the clear port. The bit ends up set.
- R10: Reset clears every pending and mask word and drops all three outputs. Reads of offsets 0x30 to 0x3C return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Single-cycle event pulse |
| evt_id | input | 7 | Event number: word in [6:5], bit in [4:0] |
| clr_valid | input | 1 | Hardware clear request |
| clr_id | input | 7 | Number of the event to clear |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 3 | Level interrupt outputs A, B, C in bits 0, 1, 2 |

## Verification
The bench tries to clear the cascade bits through word 0 and through the clear port. A design that treated them as ordinary bits would let bit 30 or bit 31 drop while the upper word still holds events.

It removes word 2 partially and then completely. This exposes a design that drops bit 31 too early, or one that never drops it.

It masks only a cascade bit on one level, then empties the upper word through the clear port. The line must fall with the cascade bit on that same edge.

It also collides events with bus and port clears on the same bit in the same cycle. A clear-first design would lose the event there. It writes masks while events are already pending, where a design that only re-evaluated on new events would keep its output stale.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 3;
    localparam int NUM_LVL   = 3;
    localparam int ID_W      = 7;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int WSEL_W    = ID_W - BIT_W;
    localparam int ADDR_W    = 6;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int SEL_W     = 2;
    localparam int NUM_REGS  = NUM_WORDS * (1 + NUM_LVL);
    localparam int PEND_BITS = NUM_WORDS * WORD_W;
    localparam int MASK_BITS = NUM_LVL * NUM_WORDS * WORD_W;
    // words that software may clear by writing ones (word 1 is bus read-only)
    localparam logic [NUM_WORDS-1:0] BUS_CLR_WORDS = 3'b101;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        KIND_PEND,
        KIND_MASK,
        KIND_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [SEL_W-1:0] lvl;
        logic [SEL_W-1:0] word;
    } reg_sel_t;

    typedef struct packed {
        logic              vld;
        logic [WSEL_W-1:0] word;
        logic [BIT_W-1:0]  pos;
    } evt_req_t;

    // bit of word 0 that summarises upper word w
    function automatic int casc_pos(input int w);
        return WORD_W - NUM_WORDS + w;
    endfunction

    function automatic word_t casc_protect();
        word_t m;
        m = '0;
        for (int w = 1; w < NUM_WORDS; w++) m[casc_pos(w)] = 1'b1;
        return m;
    endfunction

    function automatic evt_req_t split_id(input logic vld, input logic [ID_W-1:0] id);
        evt_req_t r;
        r.vld  = vld;
        r.word = id[ID_W-1:BIT_W];
        r.pos  = id[BIT_W-1:0];
        return r;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        int       idx;
        idx    = int'(a[ADDR_W-1:2]);
        s.kind = KIND_NONE;
        s.lvl  = '0;
        s.word = '0;
        if (idx < NUM_WORDS) begin
            s.kind = KIND_PEND;
            s.word = SEL_W'(idx);
        end else if (idx < NUM_REGS) begin
            s.kind = KIND_MASK;
            s.lvl  = SEL_W'((idx - NUM_WORDS) / NUM_WORDS);
            s.word = SEL_W'((idx - NUM_WORDS) % NUM_WORDS);
        end
        return s;
    endfunction
endpackage

// File: rtl/evt_agg_decode.sv
// Turns a numbered request into one-hot bit vectors per pending word.
module evt_agg_decode
    import evt_agg_pkg::*;
(
    input  logic            vld,
    input  logic [ID_W-1:0] id,
    output word_t           hit [NUM_WORDS]
);
    evt_req_t req;
    word_t    shield;

    assign req    = split_id(vld, id);
    assign shield = casc_protect();

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_t raw;
        always_comb begin
            raw = '0;
            if (req.vld && (req.word == WSEL_W'(w))) raw[req.pos] = 1'b1;
        end
        if (w == 0) begin : g_base
            // cascade positions in word 0 are not reachable by number
            assign hit[w] = raw & ~shield;
        end else begin : g_upper
            assign hit[w] = raw;
        end
    end
endmodule

// File: rtl/evt_agg_pend_word.sv
// One pending word: set wins over clear; FORCED bits follow forced_val.
module evt_agg_pend_word
    import evt_agg_pkg::*;
#(
    parameter word_t FORCED = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t set_bits,
    input  word_t port_clr,
    input  word_t bus_clr,
    input  word_t forced_val,
    output word_t q,
    output word_t nxt
);
    word_t clr_all;
    word_t kept;

    always_comb begin
        clr_all = port_clr | bus_clr;
        kept    = (q & ~clr_all) | set_bits;
        nxt     = (kept & ~FORCED) | (forced_val & FORCED);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/evt_agg_mask_bank.sv
// Mask words, one per (level, pending word) pair.
module evt_agg_mask_bank
    import evt_agg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  reg_sel_t sel,
    input  word_t    wdata,
    output word_t    q   [NUM_LVL][NUM_WORDS],
    output word_t    nxt [NUM_LVL][NUM_WORDS]
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            logic hit;
            assign hit = we && (sel.kind == KIND_MASK) &&
                         (sel.lvl == SEL_W'(l)) && (sel.word == SEL_W'(w));
            assign nxt[l][w] = hit ? wdata : q[l][w];
            always_ff @(posedge clk) begin
                if (rst) q[l][w] <= '0;
                else     q[l][w] <= nxt[l][w];
            end
        end
    end
endmodule

// File: rtl/evt_agg_level.sv
// Masked OR reduction, one request per interrupt level.
module evt_agg_level
    import evt_agg_pkg::*;
(
    input  word_t              pend [NUM_WORDS],
    input  word_t              mask [NUM_LVL][NUM_WORDS],
    output logic [NUM_LVL-1:0] req
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        word_t acc;
        always_comb begin
            acc = '0;
            for (int w = 0; w < NUM_WORDS; w++) acc = acc | (pend[w] & mask[l][w]);
            req[l] = |acc;
        end
    end
endmodule

// File: rtl/evt_cascade_agg.sv
module evt_cascade_agg
    import evt_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  logic [ID_W-1:0]    evt_id,
    input  logic               clr_valid,
    input  logic [ID_W-1:0]    clr_id,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_LVL-1:0] irq
);
    reg_sel_t           sel;
    word_t              evt_hit  [NUM_WORDS];
    word_t              clr_hit  [NUM_WORDS];
    word_t              pend_q   [NUM_WORDS];
    word_t              pend_nxt [NUM_WORDS];
    word_t              mask_q   [NUM_LVL][NUM_WORDS];
    word_t              mask_nxt [NUM_LVL][NUM_WORDS];
    logic [NUM_LVL-1:0] irq_nxt;
    logic [NUM_WORDS-1:0] upper_busy;
    logic [PEND_BITS-1:0] pend_flat;
    logic [MASK_BITS-1:0] mask_flat;

    assign sel = decode_addr(reg_addr);

    evt_agg_decode i_evt_dec (.vld(evt_valid), .id(evt_id), .hit(evt_hit));
    evt_agg_decode i_clr_dec (.vld(clr_valid), .id(clr_id), .hit(clr_hit));

    // an upper word is busy when it holds anything after this edge
    assign upper_busy[0] = 1'b0;
    for (genvar u = 1; u < NUM_WORDS; u++) begin : g_busy
        assign upper_busy[u] = |pend_nxt[u];
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pend
        word_t bus_clr;
        word_t fv;
        assign bus_clr = (reg_we && BUS_CLR_WORDS[w] && (sel.kind == KIND_PEND) &&
                          (sel.word == SEL_W'(w))) ? reg_wdata : '0;
        if (w == 0) begin : g_base
            always_comb begin
                fv = '0;
                for (int u = 1; u < NUM_WORDS; u++) fv[casc_pos(u)] = upper_busy[u];
            end
            evt_agg_pend_word #(.FORCED(casc_protect())) i_word (
                .clk(clk), .rst(rst), .set_bits(evt_hit[w]), .port_clr(clr_hit[w]),
                .bus_clr(bus_clr), .forced_val(fv), .q(pend_q[w]), .nxt(pend_nxt[w]));
        end else begin : g_upper
            assign fv = '0;
            evt_agg_pend_word #(.FORCED('0)) i_word (
                .clk(clk), .rst(rst), .set_bits(evt_hit[w]), .port_clr(clr_hit[w]),
                .bus_clr(bus_clr), .forced_val(fv), .q(pend_q[w]), .nxt(pend_nxt[w]));
        end
        assign pend_flat[w*WORD_W +: WORD_W] = pend_q[w];
    end

    evt_agg_mask_bank i_masks (
        .clk(clk), .rst(rst), .we(reg_we), .sel(sel), .wdata(reg_wdata),
        .q(mask_q), .nxt(mask_nxt));

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_mflat
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
            assign mask_flat[(l*NUM_WORDS + w)*WORD_W +: WORD_W] = mask_q[l][w];
        end
    end

    // evaluated from next state so the lines move on the same edge as registers
    evt_agg_level i_level (.pend(pend_nxt), .mask(mask_nxt), .req(irq_nxt));

    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= irq_nxt;
    end

    always_comb begin
        case (sel.kind)
            KIND_PEND: reg_rdata = pend_flat[int'(sel.word)*WORD_W +: WORD_W];
            KIND_MASK: reg_rdata = mask_flat[(int'(sel.lvl)*NUM_WORDS + int'(sel.word))*WORD_W +: WORD_W];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk
    import evt_agg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 evt_valid,
    input logic [ID_W-1:0]      evt_id,
    input logic                 clr_valid,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [WORD_W-1:0]    reg_wdata,
    input logic [NUM_LVL-1:0]   irq,
    input logic [PEND_BITS-1:0] pend_flat,
    input logic [MASK_BITS-1:0] mask_flat
);
    logic evt_real;
    assign evt_real = evt_valid && (evt_id[6:5] != 2'd3) &&
                      !((evt_id[6:5] == 2'd0) && (evt_id[4:1] == 4'hF));

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        evt_real |=> pend_flat[$past(evt_id)]); // R1

    AST_CASC_W1_SET: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_id[6:5] == 2'd1) |=> pend_flat[30]); // R3

    AST_CASC_W2_SET: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_id[6:5] == 2'd2) |=> pend_flat[31]); // R3

    AST_W0_CASC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr[5:2] == 4'd0 && (|pend_flat[63:32]) && !clr_valid)
        |=> pend_flat[30]); // R4

    AST_W1_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr[5:2] == 4'd1 && !evt_valid && !clr_valid)
        |=> $stable(pend_flat[63:32])); // R5

    AST_W2_EMPTY_DROP: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr[5:2] == 4'd2 && !evt_valid &&
         ((pend_flat[95:64] & ~reg_wdata) == '0)) |=> !pend_flat[31]); // R6

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
            irq[l] == |(pend_flat & mask_flat[l*PEND_BITS +: PEND_BITS])); // R8
    end
endmodule

bind evt_cascade_agg evt_agg_chk i_chk (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_id(evt_id),
    .clr_valid(clr_valid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .pend_flat(pend_flat), .mask_flat(mask_flat));

// File: tb/test_evt_cascade_agg.sv
`timescale 1ns/1ps
module test_evt_cascade_agg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_id = '0;
    logic        clr_valid = 1'b0;
    logic [6:0]  clr_id = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq;
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    evt_cascade_agg i_evt_cascade_agg (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_id(evt_id),
        .clr_valid(clr_valid), .clr_id(clr_id), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ev, input logic [6:0] eid, input logic cv, input logic [6:0] cid,
                       input logic we, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_valid = ev; evt_id = eid; clr_valid = cv; clr_id = cid;
        reg_we = we; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        evt_valid = 0; clr_valid = 0; reg_we = 0;
    endtask

    task automatic ev(input logic [6:0] id);  cyc(1, id, 0, 0, 0, 0, 0); endtask
    task automatic pclr(input logic [6:0] id); cyc(0, 0, 1, id, 0, 0, 0); endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d); cyc(0, 0, 0, 0, 1, a, d); endtask

    task automatic chk_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic [2:0] exp);
        check(tag, {29'b0, irq}, {29'b0, exp});
    endtask

    task automatic t_reset();
        for (int i = 0; i < 12; i++) chk_reg("R10 reset register", 6'(i*4), 32'h0);
        chk_irq("R10 reset irq", 3'b000);
    endtask

    task automatic t_decode();
        ev(7'd5);
        chk_reg("R1 word0 bit5", 6'h00, 32'h0000_0020);
        ev(7'd40);
        chk_reg("R1 word1 bit8", 6'h04, 32'h0000_0100);
        chk_reg("R3 cascade bit30", 6'h00, 32'h4000_0020);
        ev(7'd77);
        chk_reg("R1 word2 bit13", 6'h08, 32'h0000_2000);
        chk_reg("R3 cascade bit31", 6'h00, 32'hC000_0020);
        pclr(7'd40);
        chk_reg("R7 port clear word1", 6'h04, 32'h0);
        chk_reg("R7 bit30 drops", 6'h00, 32'h8000_0020);
        wr(6'h08, 32'h0000_2000);
        chk_reg("R6 word2 cleared", 6'h08, 32'h0);
        chk_reg("R6 bit31 drops", 6'h00, 32'h0000_0020);
        wr(6'h00, 32'hFFFF_FFFF);
        chk_reg("R4 word0 cleared", 6'h00, 32'h0);
    endtask

    task automatic t_ignored();
        ev(7'd100);
        chk_reg("R2 id100 word0", 6'h00, 32'h0);
        chk_reg("R2 id100 word1", 6'h04, 32'h0);
        chk_reg("R2 id100 word2", 6'h08, 32'h0);
        ev(7'd31);
        chk_reg("R2 id31 word0", 6'h00, 32'h0);
    endtask

    task automatic t_protect();
        ev(7'd33);
        chk_reg("R3 word1 bit1 cascade", 6'h00, 32'h4000_0000);
        wr(6'h00, 32'hC000_0000);
        chk_reg("R4 cascade kept on write", 6'h00, 32'h4000_0000);
        wr(6'h04, 32'hFFFF_FFFF);
        chk_reg("R5 word1 write ignored", 6'h04, 32'h0000_0002);
        pclr(7'd30);
        chk_reg("R7 port clear of id30 ignored", 6'h00, 32'h4000_0000);
        pclr(7'd33);
        chk_reg("R7 word1 emptied", 6'h00, 32'h0);
    endtask

    task automatic t_w2_partial();
        ev(7'd64);
        ev(7'd65);
        chk_reg("R1 word2 two bits", 6'h08, 32'h3);
        wr(6'h08, 32'h1);
        chk_reg("R6 partial clear", 6'h08, 32'h2);
        chk_reg("R6 bit31 kept", 6'h00, 32'h8000_0000);
        wr(6'h08, 32'h2);
        chk_reg("R6 bit31 drops on empty", 6'h00, 32'h0);
    endtask

    task automatic t_irq();
        ev(7'd3);
        chk_irq("R8 no masks", 3'b000);
        wr(6'h0C, 32'h8);
        chk_irq("R8 mask write raises A", 3'b001);
        wr(6'h2C, 32'h1);
        chk_reg("R8 mask C word2 readback", 6'h2C, 32'h1);
        ev(7'd64);
        chk_irq("R8 event raises C", 3'b101);
        wr(6'h18, 32'h8000_0000);
        chk_irq("R8 cascade mask raises B", 3'b111);
        pclr(7'd64);
        chk_irq("R8 B and C drop with empty word2", 3'b001);
        wr(6'h0C, 32'h0);
        chk_irq("R8 mask write drops A", 3'b000);
        wr(6'h00, 32'h8);
        wr(6'h18, 32'h0);
        wr(6'h2C, 32'h0);
        chk_reg("R8 word0 clean", 6'h00, 32'h0);
    endtask

    task automatic t_priority();
        cyc(1, 7'd7, 0, 0, 1, 6'h00, 32'h0000_0080);
        chk_reg("R9 event beats bus clear", 6'h00, 32'h0000_0080);
        cyc(1, 7'd34, 1, 7'd34, 0, 0, 0);
        chk_reg("R9 event beats port clear", 6'h04, 32'h0000_0004);
        chk_reg("R9 cascade set", 6'h00, 32'h4000_0080);
        pclr(7'd34);
        wr(6'h00, 32'h80);
        chk_reg("R9 cleanup", 6'h00, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(6'h30, 32'hFFFF_FFFF);
        chk_reg("R10 unmapped read", 6'h30, 32'h0);
        chk_reg("R10 unmapped write no effect", 6'h0C, 32'h0);
        chk_irq("R10 irq idle", 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_ignored();
        t_protect();
        t_w2_partial();
        t_irq();
        t_priority();
        t_unmapped();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule